// File: doc/BRIEF.md
# CPU Bank Latch and Bus Qualifier

This block sits between a 16-bit-address processor pin set and the memories and peripherals inside an FPGA. The processor shares its data pins: while its phase clock is low it places the top byte of a 24-bit address on them, and while the clock is high the pins carry real data. The block makes that phase clock from a faster system clock. It latches the bank byte at the end of each low phase and joins it with the 16 address pins. The full address is decoded into one of four targets: external SRAM, the internal boot ROM, the I/O window, or nothing.

Every select, strobe and data-pin drive is qualified. The phase clock must be high, the bus-enable input must be high, and at least one of the two address-valid flags must be set. The block drives the active-low SRAM strobes and the SRAM write-data enable. It returns read data, or 0xFF for unmapped space, onto the processor's data pins only during the high phase.

Top module: `cpu_bank_bridge`

## Requirements
- R1: `phi2` is the system clock divided by CLK_DIV with 50% duty. It is low for the first CLK_DIV/2 system cycles after reset release. `phase_end` is high in exactly the last system cycle of every half period.
- R2: The bank byte is the value on `cpu_din` at the system clock edge on which `phi2` rises. It is held until the next such edge. `sram_addr` equals {bank[3:0], cpu_addr}.
- R3: While `phi2` is low, `sram_ce_n`, `sram_oe_n` and `sram_we_n` are 1, and `rom_sel`, `io_sel`, `cpu_doe` and `sram_wdata_oe` are 0.
- R4: When `cpu_vda` and `cpu_vpa` are both 0, nothing is selected, strobed or driven. An access is valid with either flag alone.
- R5: When `cpu_be` is 0, nothing is selected, strobed or driven, whatever `cpu_rwb` and the address show.
- R6: Decode for a valid access is checked in priority order. Bank 0x00 at 0xFF00–0xFF7F selects I/O. Bank 0x00 at 0xF000–0xFFFF selects ROM when `boot_from_rom` is 1. Any other address in banks 0x00–0x0F selects SRAM (`sram_ce_n` = 0). Banks 0x10 and above select nothing.
- R7: On a valid read (`cpu_rwb` = 1), `cpu_doe` is 1 for the whole high phase. `cpu_dout` carries the selected device's data, or 0xFF when unmapped. `sram_oe_n` is 0 only on SRAM reads.
- R8: On a valid SRAM write (`cpu_rwb` = 0), `sram_wdata_oe` is 1 for the whole high phase and `sram_wdata` equals `cpu_din`. `sram_we_n` is 0 in every high-phase cycle except the last one, so the stored byte is the data present when `sram_we_n` rises.
- R9: While `rst_n` is 0, every select and strobe is inactive, `cpu_doe` is 0 and `phi2` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_from_rom | input | 1 | 1: the top 4 KB of bank 0 answers from internal ROM |
| cpu_be | input | 1 | Processor bus enable; 0 means its pins float |
| cpu_vda | input | 1 | Valid data address flag |
| cpu_vpa | input | 1 | Valid program address flag |
| cpu_rwb | input | 1 | 1 read, 0 write |
| cpu_addr | input | 16 | Processor address pins |
| cpu_din | input | 8 | Processor data pins (bank byte in low phase) |
| cpu_dout | output | 8 | Read data toward the processor |
| cpu_doe | output | 1 | Drive enable for cpu_dout |
| phi2 | output | 1 | Processor phase clock |
| phase_end | output | 1 | Last system cycle of the current half period |
| sram_addr | output | 20 | SRAM byte address |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_wdata | output | 8 | Write data toward the SRAM |
| sram_wdata_oe | output | 1 | Drive enable for sram_wdata |
| sram_rdata | input | 8 | Read data from the SRAM |
| rom_sel | output | 1 | Internal ROM select |
| rom_rdata | input | 8 | ROM read data |
| io_sel | output | 1 | I/O window select |
| io_rdata | input | 8 | I/O read data |

## Verification
The bench drives write-then-read pairs to addresses that differ only in the bank byte. A latch that samples one cycle late, or keeps the wrong bank bits, then writes the wrong SRAM byte, and the later readback shows it. Accesses near the region boundaries separate the I/O window from the ROM space around it (0xFF7F against 0xFF80). The same addresses are repeated with the ROM option off, and a wrong priority order returns the wrong device's data. Writes with both valid flags low, with bus enable low, and into unmapped banks must leave memory unchanged. A design that skipped one of these qualifiers would corrupt a byte that is later read back. On every cycle the bench compares `sram_we_n` against its own phase count, so a strobe that stays low into the last high cycle is caught at once.

// File: rtl/cpu_bank_bridge_pkg.sv
package cpu_bank_bridge_pkg;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_SRAM = 2'd1,
        TGT_ROM  = 2'd2,
        TGT_IO   = 2'd3
    } target_e;

    localparam logic [15:0] IO_FIRST  = 16'hFF00;
    localparam logic [15:0] IO_LAST   = 16'hFF7F;
    localparam logic [15:0] ROM_FIRST = 16'hF000;
    localparam logic [7:0]  OPEN_BUS  = 8'hFF;

endpackage

// File: rtl/bb_phase_gen.sv
module bb_phase_gen #(
    parameter int CLK_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic phi,
    output logic last
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          phi;
    } pg_state_t;

    pg_state_t st_d, st_q;
    logic      at_end;

    assign at_end = (st_q.cnt == CW'(HALF - 1));

    always_comb begin
        st_d = st_q;
        if (at_end) begin
            st_d.cnt = '0;
            st_d.phi = ~st_q.phi;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phi  = st_q.phi;
    assign last = at_end;
endmodule

// File: rtl/bb_bank_latch.sv
module bb_bank_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phi,
    input  logic              last,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] bank
);
    typedef struct packed {
        logic [DATA_W-1:0] bank;
    } bl_state_t;

    bl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!phi && last) st_d.bank = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bank = st_q.bank;
endmodule

// File: rtl/bb_decode.sv
module bb_decode
    import cpu_bank_bridge_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int SRAM_AW = 20
) (
    input  logic [DATA_W-1:0] bank,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rom_en,
    output target_e           tgt
);
    localparam int BANK_BITS = SRAM_AW - ADDR_W;

    logic in_sram_banks, bank_zero;

    assign in_sram_banks = ((bank >> BANK_BITS) == '0);
    assign bank_zero     = (bank == '0);

    always_comb begin
        if (!in_sram_banks)
            tgt = TGT_NONE;
        else if (bank_zero && addr >= ADDR_W'(IO_FIRST) && addr <= ADDR_W'(IO_LAST))
            tgt = TGT_IO;
        else if (bank_zero && rom_en && addr >= ADDR_W'(ROM_FIRST))
            tgt = TGT_ROM;
        else
            tgt = TGT_SRAM;
    end
endmodule

// File: rtl/cpu_bank_bridge.sv
module cpu_bank_bridge
    import cpu_bank_bridge_pkg::*;
#(
    parameter int CLK_DIV = 8,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int SRAM_AW = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boot_from_rom,
    input  logic               cpu_be,
    input  logic               cpu_vda,
    input  logic               cpu_vpa,
    input  logic               cpu_rwb,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_din,
    output logic [DATA_W-1:0]  cpu_dout,
    output logic               cpu_doe,
    output logic               phi2,
    output logic               phase_end,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic               sram_ce_n,
    output logic               sram_oe_n,
    output logic               sram_we_n,
    output logic [DATA_W-1:0]  sram_wdata,
    output logic               sram_wdata_oe,
    input  logic [DATA_W-1:0]  sram_rdata,
    output logic               rom_sel,
    input  logic [DATA_W-1:0]  rom_rdata,
    output logic               io_sel,
    input  logic [DATA_W-1:0]  io_rdata
);
    localparam int BANK_BITS = SRAM_AW - ADDR_W;

    logic              phi_w, last_w, valid;
    logic [DATA_W-1:0] bank_w;
    target_e           tgt;

    bb_phase_gen #(.CLK_DIV(CLK_DIV)) u_phase (
        .clk(clk), .rst_n(rst_n), .phi(phi_w), .last(last_w)
    );

    bb_bank_latch #(.DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .phi(phi_w), .last(last_w),
        .din(cpu_din), .bank(bank_w)
    );

    bb_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRAM_AW(SRAM_AW)) u_dec (
        .bank(bank_w), .addr(cpu_addr), .rom_en(boot_from_rom), .tgt(tgt)
    );

    assign valid = rst_n && phi_w && cpu_be && (cpu_vda || cpu_vpa);

    always_comb begin
        sram_ce_n     = !(valid && tgt == TGT_SRAM);
        sram_oe_n     = !(valid && tgt == TGT_SRAM && cpu_rwb);
        sram_we_n     = !(valid && tgt == TGT_SRAM && !cpu_rwb && !last_w);
        sram_wdata_oe = valid && tgt == TGT_SRAM && !cpu_rwb;
        rom_sel       = valid && tgt == TGT_ROM;
        io_sel        = valid && tgt == TGT_IO;
        cpu_doe       = valid && cpu_rwb;
        unique case (tgt)
            TGT_SRAM: cpu_dout = sram_rdata;
            TGT_ROM:  cpu_dout = rom_rdata;
            TGT_IO:   cpu_dout = io_rdata;
            default:  cpu_dout = DATA_W'(OPEN_BUS);
        endcase
    end

    assign sram_wdata = cpu_din;
    assign sram_addr  = {bank_w[BANK_BITS-1:0], cpu_addr};
    assign phi2       = phi_w;
    assign phase_end  = last_w;
endmodule

// File: rtl/cpu_bank_bridge_checker.sv
module cpu_bank_bridge_checker #(
    parameter int SRAM_AW = 20,
    parameter int ADDR_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cpu_be,
    input logic               cpu_vda,
    input logic               cpu_vpa,
    input logic               phi2,
    input logic               phase_end,
    input logic [SRAM_AW-1:0] sram_addr,
    input logic               sram_ce_n,
    input logic               sram_oe_n,
    input logic               sram_we_n,
    input logic               sram_wdata_oe,
    input logic               rom_sel,
    input logic               io_sel,
    input logic               cpu_doe
);
    logic quiet;
    assign quiet = sram_ce_n && sram_oe_n && sram_we_n && !sram_wdata_oe
                   && !rom_sel && !io_sel && !cpu_doe;

    p_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        phase_end |=> (phi2 != $past(phi2)));
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_end |=> $stable(phi2));
    p_bank_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phi2 && $past(phi2)) |-> $stable(sram_addr[SRAM_AW-1:ADDR_W]));
    p_low_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !phi2 |-> quiet);
    p_no_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_vda && !cpu_vpa) |-> quiet);
    p_floated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_be |-> quiet);
    p_one_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!sram_ce_n, rom_sel, io_sel}));
    p_we_early_r8: assert property (@(posedge clk) disable iff (!rst_n)
        phase_end |-> sram_we_n);

    always_comb begin
        if (!rst_n) begin
            a_reset_r9: assert (quiet && !phi2);
        end
    end
endmodule

bind cpu_bank_bridge cpu_bank_bridge_checker #(.SRAM_AW(SRAM_AW), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_be(cpu_be), .cpu_vda(cpu_vda), .cpu_vpa(cpu_vpa),
    .phi2(phi2), .phase_end(phase_end), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_wdata_oe(sram_wdata_oe), .rom_sel(rom_sel), .io_sel(io_sel),
    .cpu_doe(cpu_doe)
);

// File: tb/cpu_bank_bridge_tb_top.sv
module cpu_bank_bridge_tb_top;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_from_rom = 1'b1;
    logic        cpu_be = 1'b0, cpu_vda = 1'b0, cpu_vpa = 1'b0, cpu_rwb = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_din = '0;
    logic [7:0]  cpu_dout, sram_wdata, sram_rdata, rom_rdata, io_rdata;
    logic        cpu_doe, phi2, phase_end, sram_ce_n, sram_oe_n, sram_we_n;
    logic        sram_wdata_oe, rom_sel, io_sel;
    logic [19:0] sram_addr;

    logic [7:0]  mem [0:255];
    logic [7:0]  v_bank = '0, v_wdata = '0;
    logic [7:0]  bank_m = '0;
    logic        prev_we_n = 1'b1;
    logic [7:0]  prev_wd = '0;
    logic [7:0]  prev_idx = '0;
    int          k = 0;
    int          n_checks = 0, n_errs = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    assign sram_rdata = mem[{sram_addr[19:16], sram_addr[3:0]}];
    assign rom_rdata  = ~cpu_addr[7:0];
    assign io_rdata   = cpu_addr[7:0] ^ 8'h3C;

    cpu_bank_bridge #(.CLK_DIV(2*HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .boot_from_rom(boot_from_rom),
        .cpu_be(cpu_be), .cpu_vda(cpu_vda), .cpu_vpa(cpu_vpa), .cpu_rwb(cpu_rwb),
        .cpu_addr(cpu_addr), .cpu_din(cpu_din), .cpu_dout(cpu_dout), .cpu_doe(cpu_doe),
        .phi2(phi2), .phase_end(phase_end), .sram_addr(sram_addr),
        .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .sram_wdata(sram_wdata), .sram_wdata_oe(sram_wdata_oe), .sram_rdata(sram_rdata),
        .rom_sel(rom_sel), .rom_rdata(rom_rdata), .io_sel(io_sel), .io_rdata(io_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) k <= 0;
        else        k <= k + 1;
    end

    // Reference model, compared every cycle away from the active edge
    always @(negedge clk) begin
        logic ph, pe, valid;
        int   tgt;
        logic [7:0] rd;
        string tq;
        ph = rst_n && (((k / HALF) % 2) == 1);
        pe = rst_n && ((k % HALF) == HALF - 1);
        valid = rst_n && ph && cpu_be && (cpu_vda || cpu_vpa);
        if (bank_m >= 8'h10) tgt = 0;
        else if (bank_m == 8'h00 && cpu_addr >= 16'hFF00 && cpu_addr <= 16'hFF7F) tgt = 3;
        else if (bank_m == 8'h00 && boot_from_rom && cpu_addr >= 16'hF000) tgt = 2;
        else tgt = 1;
        rd = (tgt == 1) ? mem[{bank_m[3:0], cpu_addr[3:0]}] :
             (tgt == 2) ? ~cpu_addr[7:0] :
             (tgt == 3) ? (cpu_addr[7:0] ^ 8'h3C) : 8'hFF;
        if (!rst_n) tq = "R9";
        else if (!ph) tq = "R3";
        else if (!cpu_be) tq = "R5";
        else if (!(cpu_vda || cpu_vpa)) tq = "R4";
        else tq = "R6";
        chk("R1 phi2", 32'(phi2), 32'(ph));
        chk("R1 phase_end", 32'(phase_end), 32'(pe));
        chk("R2 sram_addr", 32'(sram_addr), 32'({bank_m[3:0], cpu_addr}));
        chk({tq, " sram_ce_n"}, 32'(sram_ce_n), 32'(!(valid && tgt == 1)));
        chk({tq, " rom_sel"}, 32'(rom_sel), 32'(valid && tgt == 2));
        chk({tq, " io_sel"}, 32'(io_sel), 32'(valid && tgt == 3));
        chk({tq, " R7 sram_oe_n"}, 32'(sram_oe_n), 32'(!(valid && tgt == 1 && cpu_rwb)));
        chk({tq, " R7 cpu_doe"}, 32'(cpu_doe), 32'(valid && cpu_rwb));
        if (valid && cpu_rwb) chk("R7 cpu_dout", 32'(cpu_dout), 32'(rd));
        chk({tq, " R8 sram_we_n"}, 32'(sram_we_n), 32'(!(valid && tgt == 1 && !cpu_rwb && !pe)));
        chk({tq, " R8 sram_wdata_oe"}, 32'(sram_wdata_oe), 32'(valid && tgt == 1 && !cpu_rwb));
        if (sram_wdata_oe) chk("R8 sram_wdata", 32'(sram_wdata), 32'(cpu_din));
        // behavioural SRAM: store on the rising write strobe
        if (!prev_we_n && sram_we_n) mem[prev_idx] = prev_wd;
        prev_we_n = sram_we_n;
        prev_wd   = sram_wdata;
        prev_idx  = {sram_addr[19:16], sram_addr[3:0]};
        if (rst_n && !ph && pe) bank_m = cpu_din;
        if (rst_n) cpu_din = ph ? v_wdata : v_bank;
    end

    task automatic cyc(input logic [7:0] bk, input logic [15:0] a, input logic rw,
                       input logic vda, input logic vpa, input logic be, input logic [7:0] wd);
        v_bank = bk; v_wdata = wd; cpu_din = bk;
        cpu_addr = a; cpu_rwb = rw; cpu_vda = vda; cpu_vpa = vpa; cpu_be = be;
        repeat (2 * HALF) @(posedge clk);
        #1;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R2: same low address, different banks
        cyc(8'h00, 16'h1231, 1'b0, 1'b1, 1'b0, 1'b1, 8'hA5);
        cyc(8'h05, 16'h1231, 1'b0, 1'b1, 1'b0, 1'b1, 8'h3C);
        cyc(8'h00, 16'h1231, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        cyc(8'h05, 16'h1231, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00);
        // R6: regions with ROM enabled
        cyc(8'h00, 16'hF012, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00);
        cyc(8'h00, 16'hFF20, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        cyc(8'h00, 16'hFF7F, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        cyc(8'h00, 16'hFF80, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        cyc(8'h00, 16'hEFFF, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        cyc(8'h12, 16'h0003, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        cyc(8'h12, 16'h0003, 1'b0, 1'b1, 1'b0, 1'b1, 8'h77);
        cyc(8'h02, 16'h0003, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        // R6: ROM disabled, top of bank 0 is SRAM, I/O still wins
        boot_from_rom = 1'b0;
        cyc(8'h00, 16'hF012, 1'b0, 1'b1, 1'b0, 1'b1, 8'h5E);
        cyc(8'h00, 16'hF012, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        cyc(8'h00, 16'hFF40, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        boot_from_rom = 1'b1;
        // R4: write with no valid flag must not land
        cyc(8'h00, 16'h1231, 1'b0, 1'b0, 1'b0, 1'b1, 8'hEE);
        cyc(8'h00, 16'h1231, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        // R5: write with bus floated must not land
        cyc(8'h05, 16'h1231, 1'b0, 1'b1, 1'b1, 1'b0, 8'hDD);
        cyc(8'h05, 16'h1231, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        // R9: reset mid-cycle
        cyc(8'h03, 16'h0444, 1'b0, 1'b1, 1'b0, 1'b1, 8'h99);
        rst_n = 1'b0;
        v_bank = 8'h00;
        bank_m = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        cyc(8'h03, 16'h0444, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_errs++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
            $finish;
        end
    end
endmodule